// File: doc/BRIEF.md
# Serial Bit-Clock Source Selector

This block decides which bit clock paces a serial audio interface: one supplied from outside, or one produced internally by dividing the master clock. It watches the external bit clock and the frame (left/right) clock. Once enough external bit-clock activity appears inside one frame-clock phase, it hands control to the external clock. When that clock goes quiet for long enough, measured in frame periods, it falls back to its own divider. Everything runs on the master clock. The two external clocks pass through synchronisers, and the chosen bit clock is delivered as a single-cycle enable plus a level that shows its phase.

The internal divider takes its rate from a master-to-frame ratio code and a format code. It realigns to every frame-clock transition, so the internal bit clock always starts a frame in a known phase. Downstream serial logic advances on `bclk_en` and does not need to know which source is in use.

Top module: `sclk_source_sel`

## Requirements
- R1: While reset is held, and on the cycle after it is released, `ext_mode` is 0 (internal source) and `bclk_en` is 0.
- R2: With the frame clock steady at either level, the 16th synchronised rising edge of `bclk_in` inside that one frame phase sets `ext_mode` to 1.
- R3: Each synchronised frame-clock transition clears the bit-edge tally, so rising edges split across two phases never reach the threshold. A bit-clock rising edge that is seen in the same cycle as a frame transition counts as the first edge of the new phase.
- R4: In external mode, `ext_mode` returns to 0 on the third synchronised frame-clock rising edge after the last `bclk_in` rising edge, which means two complete frame periods with no bit-clock activity. A bit-clock rising edge that coincides with a frame rising edge restarts the idle count, and that frame edge is not counted.
- R5: The internal bit clocks per frame period depend on the two codes. `ratio_sel` 0,1,2,3,4 selects 128,192,256,384,512 master clocks per frame, and any other code behaves as 256. Ratios 192 and 384 give 48 bits. Ratios 128, 256 and 512 give 64 bits, or 32 when `fmt_sel` is 0 (16-bit I2S).
- R6: In internal mode, `bclk_en` pulses once every ratio/bits master cycles. Each synchronised frame-clock transition restarts the divider, so the first pulse comes half a bit period after the restart. The design's latency from a `fclk_in` change to that first pulse is 3 + ratio/(2·bits) cycles.
- R7: In external mode, `bclk_en` pulses once for each rising edge of `bclk_in`, and `bclk_phase` follows the synchronised level of `bclk_in`.
- R8: `bclk_en` is only ever asserted while `bclk_phase` is 1, so it marks the rising edge of the selected bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fclk_in | input | 1 | Frame (left/right) clock, asynchronous |
| bclk_in | input | 1 | External bit clock, asynchronous |
| ratio_sel | input | 3 | Master-to-frame ratio code |
| fmt_sel | input | 3 | Serial format code; 0 = 16-bit I2S |
| ext_mode | output | 1 | 1 when the external bit clock is selected |
| bclk_en | output | 1 | One-cycle enable at each rising edge of the selected bit clock |
| bclk_phase | output | 1 | Level of the selected bit clock |

## Verification
A bit-clock rising edge and a frame-clock edge can land in the same master cycle. In that cycle the edge tally must both clear and count, and the idle count must both advance and restart. The bench creates this collision by changing `bclk_in` and `fclk_in` on the same driving edge, so both reach the synchronisers' outputs together. After 15 edges in one phase, a coinciding 16th edge with a frame flip must not switch modes, while 15 further edges must. In external mode, a bit edge that coincides with the third idle frame rise must hold the mode until three fresh frame rises have passed.

// File: rtl/sclk_sel_pkg.sv
package sclk_sel_pkg;

    localparam int MAX_DIV = 16;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    localparam logic [2:0] FMT_I2S16 = 3'd0;

    typedef enum logic [2:0] {
        RATIO_128 = 3'd0,
        RATIO_192 = 3'd1,
        RATIO_256 = 3'd2,
        RATIO_384 = 3'd3,
        RATIO_512 = 3'd4
    } ratio_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    // synchronised level and its one-cycle-delayed copy
    typedef struct packed {
        logic cur;
        logic old;
    } sync_pair_t;

    function automatic logic is_rise(input sync_pair_t p);
        return p.cur & ~p.old;
    endfunction

    function automatic logic is_toggle(input sync_pair_t p);
        return p.cur ^ p.old;
    endfunction

    // master cycles per internal bit clock
    function automatic logic [DIV_W-1:0] calc_div(input logic [2:0] ratio,
                                                  input logic [2:0] fmt);
        logic short_frame;
        short_frame = (fmt == FMT_I2S16);
        case (ratio)
            RATIO_128: return short_frame ? DIV_W'(4)  : DIV_W'(2);
            RATIO_192: return DIV_W'(4);
            RATIO_384: return DIV_W'(8);
            RATIO_512: return short_frame ? DIV_W'(16) : DIV_W'(8);
            default:   return short_frame ? DIV_W'(8)  : DIV_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/sclk_sync_edge.sv
module sclk_sync_edge
    import sclk_sel_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_in,
    output sync_pair_t pair
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              delayed;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            delayed <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], async_in};
            delayed <= chain[LAST];
        end
    end

    assign pair.cur = chain[LAST];
    assign pair.old = delayed;

endmodule

// File: rtl/sclk_ext_detect.sv
module sclk_ext_detect
    import sclk_sel_pkg::*;
#(
    parameter int EDGE_THRESH = 16,
    parameter int IDLE_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  sync_pair_t bclk_p,
    input  sync_pair_t fclk_p,
    output clk_src_e   mode
);
    localparam int CNT_W  = $clog2(EDGE_THRESH + 1);
    localparam int IDLE_W = $clog2(IDLE_FRAMES + 2);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(EDGE_THRESH);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(EDGE_THRESH - 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(IDLE_FRAMES + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_FRAMES);

    logic              b_rise, f_rise, f_flip;
    logic [CNT_W-1:0]  edge_cnt;
    logic [IDLE_W-1:0] idle_cnt;

    assign b_rise = is_rise(bclk_p);
    assign f_rise = is_rise(fclk_p);
    assign f_flip = is_toggle(fclk_p);

    // bit edges within the current frame phase
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= '0;
        end else if (f_flip) begin
            edge_cnt <= b_rise ? CNT_W'(1) : '0;
        end else if (b_rise && edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // frame rising edges since the last bit edge
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (b_rise) begin
            idle_cnt <= '0;
        end else if (f_rise && idle_cnt != IDLE_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SRC_INT;
        end else begin
            case (mode)
                SRC_INT: if (b_rise && !f_flip && edge_cnt == CNT_LAST) mode <= SRC_EXT;
                SRC_EXT: if (!b_rise && f_rise && idle_cnt == IDLE_LAST) mode <= SRC_INT;
                default: mode <= SRC_INT;
            endcase
        end
    end

    p_reset_internal_r1: assert property (@(posedge clk)
        rst |=> mode == SRC_INT);

    p_enter_needs_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_INT && !b_rise) |=> mode == SRC_INT);

    p_no_entry_on_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_INT && f_flip) |=> mode == SRC_INT);

    p_exit_needs_frame_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_EXT && !f_rise) |=> mode == SRC_EXT);

    p_edge_holds_ext_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_EXT && b_rise) |=> mode == SRC_EXT);

endmodule

// File: rtl/sclk_int_div.sv
module sclk_int_div
    import sclk_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ratio_sel,
    input  logic [2:0] fmt_sel,
    input  sync_pair_t fclk_p,
    output logic       tick,
    output logic       phase
);
    logic [DIV_W-1:0] div, half, cnt;
    logic             restart;

    assign div     = calc_div(ratio_sel, fmt_sel);
    assign half    = div >> 1;
    assign restart = is_toggle(fclk_p);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt >= div - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase = (cnt >= half);
    assign tick  = (cnt == half);

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    p_restart_low_r6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !phase && !tick);

endmodule

// File: rtl/sclk_source_sel.sv
module sclk_source_sel
    import sclk_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_THRESH = 16,
    parameter int IDLE_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fclk_in,
    input  logic       bclk_in,
    input  logic [2:0] ratio_sel,
    input  logic [2:0] fmt_sel,
    output logic       ext_mode,
    output logic       bclk_en,
    output logic       bclk_phase
);
    sync_pair_t bclk_p, fclk_p;
    clk_src_e   src;
    logic       int_tick, int_phase;

    sclk_sync_edge #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk(clk), .rst(rst), .async_in(bclk_in), .pair(bclk_p));

    sclk_sync_edge #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst(rst), .async_in(fclk_in), .pair(fclk_p));

    sclk_ext_detect #(.EDGE_THRESH(EDGE_THRESH), .IDLE_FRAMES(IDLE_FRAMES)) u_detect (
        .clk(clk), .rst(rst), .bclk_p(bclk_p), .fclk_p(fclk_p), .mode(src));

    sclk_int_div u_div (
        .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .fmt_sel(fmt_sel),
        .fclk_p(fclk_p), .tick(int_tick), .phase(int_phase));

    assign ext_mode   = (src == SRC_EXT);
    assign bclk_en    = ext_mode ? is_rise(bclk_p) : int_tick;
    assign bclk_phase = ext_mode ? bclk_p.cur      : int_phase;

    p_en_in_high_r8: assert property (@(posedge clk) disable iff (rst)
        bclk_en |-> bclk_phase);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !ext_mode);

endmodule

// File: tb/sclk_source_sel_bench.sv
module sclk_source_sel_bench;

    logic       clk = 1'b0;
    logic       rst, fclk_in, bclk_in;
    logic [2:0] ratio_sel, fmt_sel;
    logic       ext_mode, bclk_en, bclk_phase;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sclk_source_sel u_sclk_source_sel (
        .clk(clk), .rst(rst), .fclk_in(fclk_in), .bclk_in(bclk_in),
        .ratio_sel(ratio_sel), .fmt_sel(fmt_sel),
        .ext_mode(ext_mode), .bclk_en(bclk_en), .bclk_phase(bclk_phase));

    // scoreboard
    int    exp_q[$];
    string tag_q[$];
    int    win_left = 0;
    int    en_seen  = 0;

    // background frame generator
    bit fgen_on = 0;
    int fhalf   = 128;
    int fcnt    = 0;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: counts enables over a window, then pops and compares
    always @(negedge clk) begin
        if (win_left > 0) begin
            if (bclk_en) en_seen++;
            win_left--;
            if (win_left == 0) begin
                chk(tag_q.pop_front(), en_seen, exp_q.pop_front());
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (fgen_on) begin
            fcnt++;
            if (fcnt >= fhalf) begin
                fclk_in = ~fclk_in;
                fcnt = 0;
            end
        end else begin
            fcnt = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_window(input int len, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        en_seen  = 0;
        win_left = len;
    endtask

    task automatic bpulse(input int n);
        for (int i = 0; i < n; i++) begin
            bclk_in = 1'b1; tick(4);
            bclk_in = 1'b0; tick(4);
        end
    endtask

    task automatic frame_rise();
        if (fclk_in) begin
            fclk_in = 1'b0; tick(6);
        end
        fclk_in = 1'b1; tick(6);
    endtask

    function automatic int ratio_val(input int code);
        case (code)
            0: return 128;
            1: return 192;
            3: return 384;
            4: return 512;
            default: return 256;
        endcase
    endfunction

    task automatic int_case(input int code, input int fmt, input int bits);
        int r;
        r = ratio_val(code);
        ratio_sel = 3'(code);
        fmt_sel   = 3'(fmt);
        fhalf     = r / 2;
        fgen_on   = 1;
        tick(3 * r);
        open_window(4 * r, 4 * bits, $sformatf("R5 R6 ratio %0d fmt %0d", r, fmt));
        wait (win_left == 0);
        fgen_on = 0;
        tick(8);
    endtask

    initial begin
        rst = 1'b1; fclk_in = 1'b0; bclk_in = 1'b0;
        ratio_sel = 3'd2; fmt_sel = 3'd1;
        tick(4);
        chk("R1 mode in reset", int'(ext_mode), 0);
        chk("R1 enable in reset", int'(bclk_en), 0);
        rst = 1'b0;
        tick(1);
        chk("R1 mode after reset", int'(ext_mode), 0);

        // R5/R6: internal rate for each ratio/format combination
        int_case(0, 1, 64);
        int_case(1, 1, 48);
        int_case(2, 1, 64);
        int_case(3, 1, 48);
        int_case(4, 1, 64);
        int_case(0, 0, 32);
        int_case(2, 0, 32);
        int_case(4, 0, 32);
        int_case(3, 0, 48);
        int_case(7, 1, 64);

        // R6: divider restart at a frame transition (ratio 256, 64 bits, divide by 4)
        ratio_sel = 3'd2; fmt_sel = 3'd1;
        tick(21);
        fclk_in = ~fclk_in;
        tick(4); chk("R6 no pulse before half period", int'(bclk_en), 0);
        tick(1); chk("R6 first pulse after restart",  int'(bclk_en), 1);
        tick(1); chk("R6 pulse lasts one cycle",      int'(bclk_en), 0);
        tick(3); chk("R6 next pulse one period later", int'(bclk_en), 1);
        tick(10);

        // R3: edges split across phases do not switch
        bpulse(15);
        fclk_in = ~fclk_in; tick(8);
        bpulse(15);
        chk("R3 split edges stay internal", int'(ext_mode), 0);
        // R2: 16th edge in one phase switches
        bpulse(1);
        chk("R2 sixteenth edge selects external", int'(ext_mode), 1);

        // R7: enables follow external edges, phase follows level
        open_window(80, 10, "R7 one enable per external edge");
        bpulse(10);
        wait (win_left == 0);
        bclk_in = 1'b1; tick(3);
        chk("R7 phase high follows input", int'(bclk_phase), 1);
        bclk_in = 1'b0; tick(3);
        chk("R7 phase low follows input", int'(bclk_phase), 0);
        tick(4);

        // R4: two idle frames then fall back
        frame_rise(); frame_rise();
        chk("R4 still external after two rises", int'(ext_mode), 1);
        frame_rise();
        chk("R4 internal after third rise", int'(ext_mode), 0);

        // R4: coinciding bit edge restarts the idle count
        bpulse(16);
        chk("R2 re-entry to external", int'(ext_mode), 1);
        frame_rise(); frame_rise();
        fclk_in = 1'b0; tick(6);
        fclk_in = 1'b1; bclk_in = 1'b1; tick(4);
        bclk_in = 1'b0; tick(4);
        chk("R4 coinciding edge holds external", int'(ext_mode), 1);
        frame_rise(); frame_rise();
        chk("R4 two fresh rises keep external", int'(ext_mode), 1);
        frame_rise();
        chk("R4 third fresh rise returns internal", int'(ext_mode), 0);

        // R3: coinciding bit edge counts in the new phase
        tick(10);
        bpulse(15);
        fclk_in = ~fclk_in; bclk_in = 1'b1; tick(4);
        bclk_in = 1'b0; tick(4);
        chk("R3 coinciding 16th edge does not switch", int'(ext_mode), 0);
        bpulse(14);
        chk("R3 fifteen in new phase stays internal", int'(ext_mode), 0);
        bpulse(1);
        chk("R3 coinciding edge counted as first", int'(ext_mode), 1);

        // R8: enables only during the high phase, in both modes
        begin
            int bad = 0;
            open_window(64, 8, "R7 enables during phase scan");
            for (int i = 0; i < 8; i++) begin
                bclk_in = 1'b1;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (bclk_en && !bclk_phase) bad++;
                end
                bclk_in = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (bclk_en && !bclk_phase) bad++;
                end
            end
            wait (win_left == 0);
            chk("R8 external enable only when high", bad, 0);
            frame_rise(); frame_rise(); frame_rise();
            bad = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (bclk_en && !bclk_phase) bad++;
            end
            chk("R8 internal enable only when high", bad, 0);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule